// File: doc/BRIEF.md
# Flash Bus Ownership Arbiter

This block decides which of three masters may drive a shared flash bus: an embedded controller, a host interface and a parallel flash loader. The controller and the host ask for the bus through two request bits in one control register. The loader asks through a dedicated input pin. The block grants the bus to one master at a time and drives a one-hot select vector to the external flash multiplexer. It also reports the current owner as an encoded field in the same control register.

Software uses a request-and-poll scheme. It sets or clears its request bit, then reads the register until the owner field shows the expected value. Software keeps its own timeout. The arbiter therefore finishes any grant or release within two clock edges of the register write, which is far inside any microsecond-scale polling interval.

Ownership is never taken away from a master while it still requests the bus. When a master drops its request, the bus passes through idle before another master can be granted it.

Top module: `flash_owner_arb`

## Requirements
- R1: After reset the owner field reads 0 (idle), both request bits read 0 and every select output is low.
- R2: A write to the control register at byte offset 0x1D0 loads the controller request from data bit 4 and the host request from data bit 5. A read at that offset returns the owner in bits 2:0, the controller request in bit 4 and the host request in bit 5, with every other bit 0.
- R3: Write data in bits 2:0 has no effect on the owner. A write to any other address has no effect on the request bits, and a read from any other address returns 0.
- R4: Owner codes are 0 for idle, 1 for the controller, 2 for the host and 4 for the loader. When a request is raised while the bus is idle, the owner field shows the new code on the clock edge after the request register (or pin) shows it.
- R5: A master that owns the bus keeps it for as long as its request stays asserted, whatever other requests arrive.
- R6: When the owner's request drops, the owner returns to idle on the next edge. It stays idle for at least one cycle before any new grant. A grant only ever starts from idle.
- R7: When several requests are pending while the bus is idle, the loader wins first, then the controller, then the host.
- R8: The loader request comes only from the loader request input pin.
- R9: The select output is one-hot or zero. Bit 0 selects the controller, bit 1 the host and bit 2 the loader, and the output always matches the owner field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for both register write and read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr (combinational) |
| loader_req_i | input | 1 | Bus request from the parallel flash loader |
| flash_sel_o | output | 3 | One-hot flash mux select (bit 0 controller, bit 1 host, bit 2 loader) |

## Verification
The grant path is exercised in four ways. A single host request tells correct grant latency apart from an off-by-one. Controller and host requests written in the same cycle show whether the controller-over-host order is right. A host release made while the controller and loader both wait shows that the loader outranks the controller and that the idle gap exists. A loader request raised during host ownership separates a non-preempting arbiter from one that preempts. Writes that carry owner-field bits, and writes to a neighbouring address, check that those writes change nothing at the ports.

// File: rtl/flash_owner_pkg.sv
package flash_owner_pkg;

  localparam int NUM_MASTERS = 3;
  localparam int OWNER_W     = 3;

  // owner codes double as one-hot master positions
  localparam logic [OWNER_W-1:0] OWN_IDLE   = 3'd0;
  localparam logic [OWNER_W-1:0] OWN_CTRL   = 3'd1;
  localparam logic [OWNER_W-1:0] OWN_HOST   = 3'd2;
  localparam logic [OWNER_W-1:0] OWN_LOADER = 3'd4;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_HOST   = 1;
  localparam int IDX_LOADER = 2;

  // control register field positions
  localparam int FLD_OWNER_LSB = 0;
  localparam int FLD_CTRL_REQ  = 4;
  localparam int FLD_HOST_REQ  = 5;

  // fixed priority pick: loader, then controller, then host
  function automatic logic [OWNER_W-1:0] pick_owner(input logic [NUM_MASTERS-1:0] req);
    logic [OWNER_W-1:0] w;
    w = OWN_IDLE;
    if (req[IDX_LOADER])      w = OWN_LOADER;
    else if (req[IDX_CTRL])   w = OWN_CTRL;
    else if (req[IDX_HOST])   w = OWN_HOST;
    return w;
  endfunction

  // is the current owner still requesting
  function automatic logic owner_holds(input logic [OWNER_W-1:0] owner,
                                       input logic [NUM_MASTERS-1:0] req);
    return |(owner & req);
  endfunction

endpackage

// File: rtl/flash_owner_regs.sv
module flash_owner_regs
  import flash_owner_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'h1D0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [OWNER_W-1:0]  owner,
  output logic                ctrl_req,
  output logic                host_req,
  output logic [DATA_W-1:0]   rdata
);

  logic hit;
  logic wr_hit;
  logic unused_wbits;

  assign hit    = (addr == CTRL_OFFSET);
  assign wr_hit = wr_en && hit;
  // owner bits and upper bits of write data are deliberately dropped
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_req <= 1'b0;
      host_req <= 1'b0;
    end else if (wr_hit) begin
      ctrl_req <= wdata[FLD_CTRL_REQ];
      host_req <= wdata[FLD_HOST_REQ];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[FLD_OWNER_LSB +: OWNER_W] = owner;
      rdata[FLD_CTRL_REQ]             = ctrl_req;
      rdata[FLD_HOST_REQ]             = host_req;
    end
  end

endmodule

// File: rtl/flash_owner_fsm.sv
module flash_owner_fsm
  import flash_owner_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  output logic [OWNER_W-1:0]     owner,
  output logic                   grant_evt,
  output logic                   release_evt
);

  logic [OWNER_W-1:0] owner_d;
  logic               is_idle;

  assign is_idle     = (owner == OWN_IDLE);
  assign grant_evt   = is_idle && (pick_owner(req) != OWN_IDLE);
  assign release_evt = !is_idle && !owner_holds(owner, req);

  always_comb begin
    owner_d = owner;
    if (is_idle)          owner_d = pick_owner(req);
    else if (release_evt) owner_d = OWN_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner <= OWN_IDLE;
    else        owner <= owner_d;
  end

endmodule

// File: rtl/flash_owner_sel.sv
module flash_owner_sel
  import flash_owner_pkg::*;
(
  input  logic [OWNER_W-1:0]     owner,
  output logic [NUM_MASTERS-1:0] sel
);

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_sel
    localparam logic [OWNER_W-1:0] CODE = OWNER_W'(1) << i;
    assign sel[i] = (owner == CODE);
  end

endmodule

// File: rtl/flash_owner_arb.sv
module flash_owner_arb
  import flash_owner_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'h1D0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              loader_req_i,
  output logic [2:0]        flash_sel_o
);

  logic [OWNER_W-1:0]     owner_code;
  logic                   ctrl_req;
  logic                   host_req;
  logic [NUM_MASTERS-1:0] req_vec;
  logic                   grant_evt;
  logic                   release_evt;

  assign req_vec[IDX_CTRL]   = ctrl_req;
  assign req_vec[IDX_HOST]   = host_req;
  assign req_vec[IDX_LOADER] = loader_req_i;

  flash_owner_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFFSET(CTRL_OFFSET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .owner(owner_code), .ctrl_req(ctrl_req),
    .host_req(host_req), .rdata(reg_rdata)
  );

  flash_owner_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req_vec), .owner(owner_code),
    .grant_evt(grant_evt), .release_evt(release_evt)
  );

  flash_owner_sel u_sel (
    .owner(owner_code), .sel(flash_sel_o)
  );

endmodule

// File: rtl/flash_owner_arb_chk.sv
module flash_owner_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] owner_code,
  input logic [2:0] req_vec,
  input logic [2:0] sel,
  input logic       grant_evt,
  input logic       release_evt
);

  // R1: reset drives owner to idle
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (owner_code == 3'd0));

  // R4: only legal owner codes
  assert_legal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_code == 3'd0) || (owner_code == 3'd1) || (owner_code == 3'd2) || (owner_code == 3'd4));

  // R5: host keeps the bus while requesting
  assert_host_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_code == 3'd2 && req_vec[1]) |=> (owner_code == 3'd2));

  // R5: controller keeps the bus while requesting
  assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_code == 3'd1 && req_vec[0]) |=> (owner_code == 3'd1));

  // R6: a release event leads to idle
  assert_release_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (owner_code == 3'd0));

  // R6: a change to a non-idle owner only follows idle
  assert_grant_from_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_code != 3'd0 && !$stable(owner_code)) |-> ($past(owner_code) == 3'd0));

  // R7: a loader request in idle wins
  assert_loader_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_code == 3'd0 && req_vec[2]) |=> (owner_code == 3'd4));

  // R4: a grant event moves off idle
  assert_grant_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |=> (owner_code != 3'd0));

  // R9: select one-hot and equal to owner
  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel) && (sel == owner_code));

endmodule

bind flash_owner_arb flash_owner_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .owner_code(owner_code), .req_vec(req_vec),
  .sel(flash_sel_o), .grant_evt(grant_evt), .release_evt(release_evt)
);

// File: tb/flash_owner_arb_tb.sv
module flash_owner_arb_tb;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] CTRL = 12'h1D0;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr_en = 1'b0;
  logic [ADDR_W-1:0] reg_addr = CTRL;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              loader_req_i = 1'b0;
  logic [2:0]        flash_sel_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  flash_owner_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFFSET(CTRL)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .loader_req_i(loader_req_i),
    .flash_sel_o(flash_sel_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // expected read word from request bits and owner
  function automatic logic [31:0] ctrl_word(input logic [2:0] own, input bit c, input bit h);
    return {26'd0, h, c, 1'b0, own};
  endfunction

  function automatic logic [2:0] sel_of(input logic [2:0] own);
    return own; // bit0 ctrl, bit1 host, bit2 loader
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_addr  = CTRL;
  endtask

  task automatic check_state(input string tag, input logic [2:0] own, input bit c, input bit h);
    reg_addr = CTRL;
    #1;
    check(reg_rdata == ctrl_word(own, c, h), tag, reg_rdata, ctrl_word(own, c, h));
    check(flash_sel_o == sel_of(own), {tag, " R9 sel"}, {29'd0, flash_sel_o}, {29'd0, sel_of(own)});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    reg_wr_en = 1'b0;
    loader_req_i = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_state("R1 reset", 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_host_grant();
    do_reset();
    wr(CTRL, 32'h20);
    check_state("R2 host bit set, owner not yet", 3'd0, 1'b0, 1'b1);
    cycles(1);
    check_state("R4 host granted", 3'd2, 1'b0, 1'b1);
    wr(CTRL, 32'h0);
    check_state("R2 host bit cleared", 3'd2, 1'b0, 1'b0);
    cycles(1);
    check_state("R6 host released", 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_ignored();
    do_reset();
    wr(CTRL, 32'h20);
    cycles(1);
    wr(CTRL, 32'h27);
    cycles(2);
    check_state("R3 owner bits write ignored", 3'd2, 1'b0, 1'b1);
    wr(CTRL + 12'h4, 32'h0);
    cycles(2);
    check_state("R3 other address write ignored", 3'd2, 1'b0, 1'b1);
    reg_addr = CTRL + 12'h4;
    #1;
    check(reg_rdata == 32'h0, "R3 other address reads 0", reg_rdata, 32'h0);
    reg_addr = CTRL;
  endtask

  task automatic t_ctrl_over_host();
    do_reset();
    wr(CTRL, 32'h30);
    cycles(1);
    check_state("R7 ctrl beats host", 3'd1, 1'b1, 1'b1);
    wr(CTRL, 32'h20);
    cycles(1);
    check_state("R6 idle gap after ctrl", 3'd0, 1'b0, 1'b1);
    cycles(1);
    check_state("R6 host after gap", 3'd2, 1'b0, 1'b1);
  endtask

  task automatic t_no_preempt_and_loader();
    do_reset();
    wr(CTRL, 32'h20);
    cycles(1);
    loader_req_i = 1'b1;
    wr(CTRL, 32'h30);
    cycles(3);
    check_state("R5 host not preempted", 3'd2, 1'b1, 1'b1);
    wr(CTRL, 32'h10);
    cycles(1);
    check_state("R6 idle before re-grant", 3'd0, 1'b1, 1'b0);
    cycles(1);
    check_state("R7 R8 loader beats ctrl", 3'd4, 1'b1, 1'b0);
    loader_req_i = 1'b0;
    cycles(1);
    check_state("R8 loader released by pin", 3'd0, 1'b1, 1'b0);
    cycles(1);
    check_state("R7 ctrl after loader", 3'd1, 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_host_grant();
    t_ignored();
    t_ctrl_over_host();
    t_no_preempt_and_loader();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule